// File: doc/BRIEF.md
# Carry-Save Partial Product Accumulator

This block reduces the partial-product rows of a radix-4 recoded multiplier into the final product. It takes seventeen unshifted 64-bit rows and one 64-bit correction word, weights row k by 2^(2k), and adds everything into one 64-bit result taken modulo 2^64. The correction word carries the "+1" bits that finish the two's-complement negation of rows whose recoded digit was negative. Those rows arrive already inverted.

The adder array uses only full and half adders. It is a linear chain of carry-save stages. The first stage compresses the correction word, row 0 and row 1. Each later stage compresses the previous sum, the previous carry moved up one bit, and the next row at its weight. Carries move diagonally into the next stage and never ripple inside a stage. The last stage absorbs row 16 and then ripples its carries horizontally to resolve the redundant pair.

The result is held in one output register with a valid/ready handshake. A new operand set is accepted whenever the register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is frozen and no input is taken.

Top module: `csa_accum`

## Requirements
- R1: One cycle after an accepted input, `out_product` equals (`corr_i` + the sum over k of row k × 2^(2k)) mod 2^64, where row k is `rows_i[64k+63:64k]`.
- R2: Row k is weighted by 2^(2k). Its bits that would land above bit 63 are discarded, so all-ones in row 16 alone gives 0xFFFFFFFF00000000.
- R3: The correction word is added at weight 2^0, with no shift.
- R4: When the rows and correction come from radix-4 recoding of a 33-bit extended multiplier and multiplicand, the result is the exact product mod 2^64 in all four signed/unsigned combinations. This includes 0x80000000×0x80000000 signed and 0xFFFFFFFF×0xFFFFFFFF unsigned.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An input accepted on a clock edge makes `out_valid` high after that edge. Every accepted input yields exactly one result, in order.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_product` does not change.
- R7: After reset `out_valid` is low and `in_ready` is high.
- R8: A result can be drained and a new input accepted in the same cycle, which gives one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Operand set will be taken on this edge |
| rows_i | input | 1088 | Seventeen unshifted 64-bit rows; row k occupies bits 64k+63..64k |
| corr_i | input | 64 | Negation correction word, added unshifted |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_product | output | 64 | Sum of all rows modulo 2^64 |

## Verification
The two events that can coincide are draining the held result and accepting the next operand set on the same edge. This must not drop, duplicate or reorder a result. The bench provokes it by sending operand sets back to back while `out_ready` is driven by a random pattern, so that the register is sometimes freed and refilled in one cycle and sometimes stalled. It judges the run by matching every drained result in order against a scoreboard queue. It also counts the cycles where both handshakes fire together and checks that such cycles occurred.

// File: rtl/csa_accum_pkg.sv
package csa_accum_pkg;
  localparam int unsigned ACC_W     = 64;
  localparam int unsigned ACC_ROWS  = 17;
  localparam int unsigned ACC_SHIFT = 2;
endpackage

// File: rtl/accum_fa.sv
module accum_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ z;
    co = (x & y) | (x & z) | (y & z);
  end
endmodule

// File: rtl/accum_csa_row.sv
// One carry-save level: three words in, a sum word and a carry word out.
// The carry word is already moved up one bit (bit 0 is zero); the carry
// out of the top bit falls outside the modulus and is not formed.
module accum_csa_row #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_sh_o
);
  assign carry_sh_o[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    end else begin : g_fa
      accum_fa u_fa (
        .x  (a_i[i]),
        .y  (b_i[i]),
        .z  (c_i[i]),
        .s  (sum_o[i]),
        .co (carry_sh_o[i+1])
      );
    end
  end
endmodule

// File: rtl/accum_ripple.sv
// Horizontal carry resolution of a sum word and an already-shifted carry
// word. Bit 0 of the carry word is zero, so bit 0 is a half adder.
module accum_ripple #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] carry_sh_i,
  output logic [W-1:0] result_o
);
  logic [W-1:0] chain;

  assign result_o[0] = sum_i[0] ^ carry_sh_i[0];
  assign chain[0]    = sum_i[0] & carry_sh_i[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign result_o[i] = sum_i[i] ^ carry_sh_i[i] ^ chain[i-1];
      assign chain[i]    = 1'b0;
    end else begin : g_fa
      accum_fa u_fa (
        .x  (sum_i[i]),
        .y  (carry_sh_i[i]),
        .z  (chain[i-1]),
        .s  (result_o[i]),
        .co (chain[i])
      );
    end
  end
endmodule

// File: rtl/accum_array.sv
// Linear carry-save chain: stage 0 takes the correction word, row 0 and
// row 1; stage j takes the previous sum, previous carry and row j+1. The
// last row goes through one more carry-save level, then the ripple stage.
module accum_array #(
  parameter int unsigned W     = 64,
  parameter int unsigned ROWS  = 17,
  parameter int unsigned SHIFT = 2
) (
  input  logic [ROWS*W-1:0] rows_i,
  input  logic [W-1:0]      corr_i,
  output logic [W-1:0]      product_o
);
  localparam int unsigned NCSA = ROWS - 2;

  logic [W-1:0] row_pos [ROWS];
  logic [W-1:0] st_sum  [NCSA];
  logic [W-1:0] st_cry  [NCSA];
  logic [W-1:0] fin_sum;
  logic [W-1:0] fin_cry;

  for (genvar k = 0; k < ROWS; k++) begin : g_align
    assign row_pos[k] = rows_i[k*W +: W] << (SHIFT * k);
  end

  for (genvar j = 0; j < NCSA; j++) begin : g_stage
    if (j == 0) begin : g_first
      accum_csa_row #(.W(W)) u_row (
        .a_i        (corr_i),
        .b_i        (row_pos[0]),
        .c_i        (row_pos[1]),
        .sum_o      (st_sum[j]),
        .carry_sh_o (st_cry[j])
      );
    end else begin : g_next
      accum_csa_row #(.W(W)) u_row (
        .a_i        (st_sum[j-1]),
        .b_i        (st_cry[j-1]),
        .c_i        (row_pos[j+1]),
        .sum_o      (st_sum[j]),
        .carry_sh_o (st_cry[j])
      );
    end
  end

  accum_csa_row #(.W(W)) u_last (
    .a_i        (st_sum[NCSA-1]),
    .b_i        (st_cry[NCSA-1]),
    .c_i        (row_pos[ROWS-1]),
    .sum_o      (fin_sum),
    .carry_sh_o (fin_cry)
  );

  accum_ripple #(.W(W)) u_cpa (
    .sum_i      (fin_sum),
    .carry_sh_i (fin_cry),
    .result_o   (product_o)
  );
endmodule

// File: rtl/csa_accum.sv
module csa_accum
  import csa_accum_pkg::*;
#(
  parameter int unsigned W     = ACC_W,
  parameter int unsigned ROWS  = ACC_ROWS,
  parameter int unsigned SHIFT = ACC_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ROWS*W-1:0] rows_i,
  input  logic [W-1:0]      corr_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_product
);
  logic [W-1:0] sum_comb;
  logic         take;

  accum_array #(.W(W), .ROWS(ROWS), .SHIFT(SHIFT)) u_array (
    .rows_i    (rows_i),
    .corr_i    (corr_i),
    .product_o (sum_comb)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_product <= sum_comb;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/csa_accum_chk.sv
module csa_accum_chk #(
  parameter int unsigned W     = 64,
  parameter int unsigned ROWS  = 17,
  parameter int unsigned SHIFT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ROWS*W-1:0] rows_i,
  input logic [W-1:0]      corr_i,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_product
);
  logic [W-1:0] ref_sum;

  always_comb begin
    ref_sum = corr_i;
    for (int k = 0; k < ROWS; k++) begin
      ref_sum = ref_sum + (rows_i[k*W +: W] << (SHIFT * k));
    end
  end

  a_r1_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_product == $past(ref_sum)));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

  a_r5_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r5_empty_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r8_drain_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

bind csa_accum csa_accum_chk #(.W(W), .ROWS(ROWS), .SHIFT(SHIFT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .rows_i      (rows_i),
  .corr_i      (corr_i),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_product (out_product)
);

// File: tb/csa_accum_bench.sv
`timescale 1ns/1ps
module csa_accum_bench;
  localparam int W = 64;
  localparam int ROWS = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ROWS*W-1:0] rows_i = '0;
  logic [W-1:0]      corr_i = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [W-1:0]      out_product;

  int errors = 0;
  int checks = 0;
  int sent = 0;
  int received = 0;
  int overlap = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [W-1:0] q_exp [$];
  string        q_tag [$];

  always #4 clk = ~clk;

  csa_accum u_csa_accum (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .rows_i (rows_i), .corr_i (corr_i), .out_valid (out_valid),
    .out_ready (out_ready), .out_product (out_product)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Radix-4 recoding of the multiplier x against multiplicand y.
  task automatic booth(input logic [31:0] x, input logic [31:0] y,
                       input bit xs, input bit ys,
                       output logic [ROWS*W-1:0] rows, output logic [W-1:0] corr);
    logic [32:0] a33;
    logic [34:0] p;
    logic [W-1:0] b;
    a33  = {xs & x[31], x};
    b    = ys ? {{32{y[31]}}, y} : {32'd0, y};
    p    = {a33[32], a33, 1'b0};
    rows = '0;
    corr = '0;
    for (int k = 0; k < ROWS; k++) begin
      logic [2:0] g;
      logic [W-1:0] m;
      logic neg;
      g   = p[2*k +: 3];
      neg = g[2] & ~(g[1] & g[0]);
      if (g == 3'b100 || g == 3'b011) m = b << 1;
      else if (g[1] ^ g[0])           m = b;
      else                            m = '0;
      rows[k*W +: W] = neg ? ~m : m;
      corr[2*k] = neg;
    end
  endtask

  function automatic logic [W-1:0] ref_sum(input logic [ROWS*W-1:0] rows, input logic [W-1:0] corr);
    logic [W-1:0] s;
    s = corr;
    for (int k = 0; k < ROWS; k++) s = s + (rows[k*W +: W] << (2 * k));
    return s;
  endfunction

  // Called just after a rising edge; leaves in_valid high for chaining.
  task automatic send(input logic [ROWS*W-1:0] rows, input logic [W-1:0] corr,
                      input logic [W-1:0] exp, input string tag);
    rows_i   = rows;
    corr_i   = corr;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    sent++;
    @(posedge clk);
    #1;
  endtask

  task automatic send_mul(input logic [31:0] x, input logic [31:0] y, input bit xs, input bit ys);
    logic [ROWS*W-1:0] r;
    logic [W-1:0] c;
    logic [W-1:0] ex, ey;
    booth(x, y, xs, ys, r, c);
    ex = xs ? {{32{x[31]}}, x} : {32'd0, x};
    ey = ys ? {{32{y[31]}}, y} : {32'd0, y};
    send(r, c, ex * ey, "R4 product");
  endtask

  // Output side: random back-pressure when enabled.
  always @(posedge clk) begin
    #1;
    out_ready <= stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor / scoreboard.
  bit           prev_stall = 1'b0;
  logic [W-1:0] held = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || out_product !== held) begin
          errors++;
          $display("FAIL R6 actual=%b/%h expected=1/%h", out_valid, out_product, held);
        end
      end
      if (in_valid && in_ready && out_valid && out_ready) overlap++;
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 actual=unexpected result %h expected=none", out_product);
        end else begin
          logic [W-1:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          received++;
          check(t, out_product, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      held = out_product;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [ROWS*W-1:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R7 in_ready after reset", {63'd0, in_ready}, 64'd1);
    @(posedge clk); #1;

    // R2: single rows at their weights, including drop above bit 63
    for (int k = 0; k < ROWS; k++) begin
      r = '0;
      r[k*W] = 1'b1;
      send(r, '0, 64'd1 << (2 * k), "R2 row weight");
    end
    r = '0;
    r[16*W +: W] = '1;
    send(r, '0, 64'hFFFF_FFFF_0000_0000, "R2 top row truncation");
    // R3: correction unshifted
    send('0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R3 correction");
    // R1: all ones everywhere
    send('1, '1, ref_sum('1, '1), "R1 all ones");
    // R1: random rows
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] c;
      for (int i = 0; i < ROWS * 2; i++) r[i*32 +: 32] = $urandom;
      c = {$urandom, $urandom};
      send(r, c, ref_sum(r, c), "R1 random rows");
    end
    // R4: corner products in every mode
    send_mul(32'h8000_0000, 32'h8000_0000, 1, 1);
    send_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    send_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    send_mul(32'hFFFF_FFFF, 32'h7FFF_FFFF, 1, 0);
    send_mul(32'h8000_0000, 32'hFFFF_FFFF, 0, 1);
    send_mul(32'h0000_0000, 32'h8000_0000, 1, 1);
    send_mul(32'h7FFF_FFFF, 32'h8000_0000, 1, 1);
    in_valid = 1'b0;

    // R8 and R6: back-to-back traffic under random back-pressure
    stall_mode = 1'b1;
    @(posedge clk); #1;
    for (int n = 0; n < 200; n++) begin
      send_mul($urandom, $urandom, n[0], n[1]);
    end
    in_valid = 1'b0;
    stall_mode = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R5 results equal accepted inputs", 64'(received), 64'(sent));
    check("R5 queue drained", 64'(q_exp.size()), 64'd0);
    check("R8 drain and accept in one cycle seen", 64'(overlap > 0), 64'd1);
    check("R7 idle after drain", {63'd0, out_valid}, 64'd0);
    finish_run();
  end
endmodule